// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt lines from devices on a board and presents a single 4-bit interrupt level to a processor. Each line belongs to a fixed priority level and to a fixed, non-contiguous bit position in a 16-bit word. The live input states are spread into those positions to form a monitor word. A programmable enable mask gates that word. The pending source with the smallest level wins, and the output carries that level inverted (XOR 15). When nothing is pending the output is zero.

A small 16-bit register window sits on a simple synchronous bus made of a byte address, a write enable and write data, with read data decoded combinationally from the address. The window holds the enable mask, a general-purpose output port, a fixed version word and a power-off control that emits a shutdown strobe. The level output is registered. Because it is computed from the mask value being written in the same cycle, a mask write and an input change both show at the output one clock later.

Top module: `irq_level_agg`

## Requirements
- R1: Source n (input bit n of `irq_src`) occupies word bit b of the mask and monitor words, with (n,b) = (0,11) (1,9) (2,8) (3,12) (4,10) (5,6) (6,5) (7,4) (8,7) (9,14) (10,13) (11,0) (12,15). A source is pending only while its input is high and its mask bit is 1; mask bits 1, 2 and 3 enable nothing.
- R2: When several sources are pending, the one with the smallest n wins.
- R3: `irq_level` equals the winning n XOR 15. With no pending source it is 0, so source 0 yields 15.
- R4: `irq_level` is registered. It reflects input and mask changes one clock edge after they happen, and a mask write takes effect on the same edge that stores it.
- R5: The enable mask is read/write at byte offset 0x00 and reads back the last value written.
- R6: The output port is read/write at offset 0x36. Its value drives `gpo`.
- R7: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R8: Offset 0x30 reads 0. A write there with data bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R9: Any other offset, odd offsets included, reads 0, and a write there changes neither the mask, the port nor the outputs.
- R10: Reset clears the mask and the output port. `irq_level`, `gpo` and `shutdown_req` are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 13 | Level-sensitive interrupt inputs, bit n is source n |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_level | output | 4 | Encoded interrupt level to the processor |
| gpo | output | 16 | General-purpose output port |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
Two events can meet on one edge: a write to the enable mask, and a change on the interrupt inputs. The bench makes both happen together. It raises a source whose bit was masked off and, in the same cycle, writes a mask that enables that bit. The level read one edge later must show the new source as the winner, which proves the encoder used the incoming mask and not the stored one. A separate test changes only an input and samples just before and just after the edge, to pin the single cycle of latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned SRC_N    = 13;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned OFS_W    = 6;
  localparam logic [LVL_W-1:0] LVL_NONE = 4'hF;

  // Fixed word bit carried by each priority level (level == source index).
  function automatic logic [3:0] src_bit(input logic [3:0] lvl);
    case (lvl)
      4'd0:    return 4'd11;
      4'd1:    return 4'd9;
      4'd2:    return 4'd8;
      4'd3:    return 4'd12;
      4'd4:    return 4'd10;
      4'd5:    return 4'd6;
      4'd6:    return 4'd5;
      4'd7:    return 4'd4;
      4'd8:    return 4'd7;
      4'd9:    return 4'd14;
      4'd10:   return 4'd13;
      4'd11:   return 4'd0;
      default: return 4'd15;
    endcase
  endfunction

  // Output code for a winning level; the idle level maps to zero.
  function automatic logic [LVL_W-1:0] lvl_code(input logic [LVL_W-1:0] lvl);
    return lvl ^ LVL_NONE;
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned AW = OFS_W,
  parameter int unsigned DW = WORD_W,
  parameter logic [DW-1:0] VERSION = 16'h0010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] mask_q_o,
  output logic [DW-1:0] mask_nx_o,
  output logic [DW-1:0] port_o,
  output logic          shutdown_o
);
  localparam logic [AW-1:0] OFS_MASK = AW'(6'h00);
  localparam logic [AW-1:0] OFS_PWR  = AW'(6'h30);
  localparam logic [AW-1:0] OFS_VER  = AW'(6'h32);
  localparam logic [AW-1:0] OFS_PORT = AW'(6'h36);

  logic [DW-1:0] mask_q, port_q;
  logic          shut_q;

  // Decoded write events, named for the assertions.
  logic mask_hit, port_hit, pwr_hit, pwr_fire;
  assign mask_hit = we_i && (addr_i == OFS_MASK);
  assign port_hit = we_i && (addr_i == OFS_PORT);
  assign pwr_hit  = we_i && (addr_i == OFS_PWR);
  assign pwr_fire = pwr_hit && wdata_i[0];

  assign mask_nx_o = mask_hit ? wdata_i : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      port_q <= '0;
      shut_q <= 1'b0;
    end else begin
      mask_q <= mask_nx_o;
      if (port_hit) port_q <= wdata_i;
      shut_q <= pwr_fire;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_MASK: rdata_o = mask_q;
      OFS_PORT: rdata_o = port_q;
      OFS_VER:  rdata_o = VERSION;
      default:  rdata_o = '0;
    endcase
  end

  assign mask_q_o   = mask_q;
  assign port_o     = port_q;
  assign shutdown_o = shut_q;

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |-> $past(pwr_hit && wdata_i[0])); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mask_hit) |-> $stable(mask_q)); // R5
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(port_hit) |-> $stable(port_q)); // R6
endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned DW    = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [DW-1:0]    mask_nx_i,
  output logic [LVL_W-1:0] level_o
);
  logic [DW-1:0]    monitor;
  logic [N_SRC-1:0] pend_src;
  logic [N_SRC:0]   lower;
  logic [N_SRC-1:0] win;
  logic [LVL_W-1:0] win_lvl;
  logic [LVL_W-1:0] level_q;

  // Live input states spread into their word positions.
  always_comb begin
    monitor = '0;
    for (int i = 0; i < N_SRC; i++) monitor[src_bit(4'(i))] = src_i[i];
  end

  assign lower[0] = 1'b0;
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign pend_src[g]  = monitor[src_bit(4'(g))] & mask_nx_i[src_bit(4'(g))];
    assign lower[g+1]   = lower[g] | pend_src[g];
    assign win[g]       = pend_src[g] & ~lower[g];
  end

  always_comb begin
    win_lvl = LVL_NONE;
    for (int i = 0; i < N_SRC; i++) if (win[i]) win_lvl = LVL_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= lvl_code(win_lvl);
  end

  assign level_o = level_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_src) == '0) |-> (level_q == '0)); // R3
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != '0) |-> ((($past(pend_src) >> (LVL_NONE ^ level_q)) & N_SRC'(1)) != '0)); // R1
  AST_NO_LOWER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != '0) |->
      (($past(pend_src) & ((N_SRC'(1) << (LVL_NONE ^ level_q)) - N_SRC'(1))) == '0)); // R2
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned AW    = OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [LVL_W-1:0] irq_level,
  output logic [DW-1:0]    gpo,
  output logic             shutdown_req
);
  logic [DW-1:0] mask_q, mask_nx;

  irq_agg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .mask_q_o   (mask_q),
    .mask_nx_o  (mask_nx),
    .port_o     (gpo),
    .shutdown_o (shutdown_req)
  );

  irq_agg_prio #(.N_SRC(N_SRC), .DW(DW)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (irq_src),
    .mask_nx_i (mask_nx),
    .level_o   (irq_level)
  );

  AST_LEVEL_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_nx) == '0) |-> (irq_level == '0)); // R4
  AST_RESET_VALUES: assert property (@(posedge clk)
    !rst_n |-> (irq_level == '0 && gpo == '0 && !shutdown_req && mask_q == '0)); // R10
endmodule

// File: tb/test_irq_level_agg.sv
module test_irq_level_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_src = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_level;
  logic [15:0] gpo;
  logic        shutdown_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_level_agg i_irq_level_agg (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .gpo(gpo), .shutdown_req(shutdown_req)
  );

  // {sources, mask, expected level code}
  localparam logic [32:0] VEC [0:13] = '{
    {13'h0000, 16'hFFFF, 4'd0},
    {13'h0001, 16'hFFFF, 4'd15},
    {13'h0001, 16'hF7FF, 4'd0},
    {13'h0220, 16'hFFFF, 4'd10},
    {13'h0220, 16'hFFBF, 4'd6},
    {13'h1000, 16'h8000, 4'd3},
    {13'h1FFF, 16'h0001, 4'd4},
    {13'h1FFF, 16'h0000, 4'd0},
    {13'h0018, 16'h1400, 4'd12},
    {13'h0080, 16'h0010, 4'd8},
    {13'h0100, 16'h0080, 4'd7},
    {13'h0006, 16'h0100, 4'd13},
    {13'h0440, 16'h2000, 4'd5},
    {13'h1FFF, 16'h000E, 4'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 level", {12'd0, irq_level}, 16'd0);
    check("R10 gpo", gpo, 16'd0);
    check("R10 shutdown", {15'd0, shutdown_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R10 mask", 6'h00, 16'h0000);

    // R1 R2 R3 table walk
    foreach (VEC[k]) begin
      irq_src = VEC[k][32:20];
      wr(6'h00, VEC[k][19:4]);
      check($sformatf("R2 R3 vec %0d", k), {12'd0, irq_level}, {12'd0, VEC[k][3:0]});
      rd("R5 mask readback", 6'h00, VEC[k][19:4]);
    end

    // R4 latency: input change only
    irq_src = '0;
    wr(6'h00, 16'hFFFF);
    @(negedge clk);
    irq_src = 13'h0080;
    #1;
    check("R4 before edge", {12'd0, irq_level}, 16'd0);
    @(negedge clk);
    check("R4 after edge", {12'd0, irq_level}, 16'd8);

    // R4 concurrent mask write and input rise
    irq_src = '0;
    wr(6'h00, 16'h0000);
    @(negedge clk);
    irq_src = 13'h0010;
    wr(6'h00, 16'h0400);
    check("R4 concurrent", {12'd0, irq_level}, 16'd11);

    // R6 output port
    wr(6'h36, 16'hA5C3);
    check("R6 gpo", gpo, 16'hA5C3);
    rd("R6 readback", 6'h36, 16'hA5C3);

    // R7 version
    rd("R7 read", 6'h32, 16'h0010);
    wr(6'h32, 16'hBEEF);
    rd("R7 after write", 6'h32, 16'h0010);

    // R8 power-off
    rd("R8 read", 6'h30, 16'h0000);
    wr(6'h30, 16'h0001);
    check("R8 pulse", {15'd0, shutdown_req}, 16'd1);
    @(negedge clk);
    check("R8 pulse ends", {15'd0, shutdown_req}, 16'd0);
    wr(6'h30, 16'hFFFE);
    check("R8 bit0 clear", {15'd0, shutdown_req}, 16'd0);

    // R9 unmapped and odd offsets
    rd("R9 read 0x10", 6'h10, 16'h0000);
    rd("R9 read 0x01", 6'h01, 16'h0000);
    wr(6'h01, 16'hFFFF);
    wr(6'h04, 16'h1234);
    wr(6'h37, 16'h0000);
    rd("R9 mask kept", 6'h00, 16'h0400);
    rd("R9 port kept", 6'h36, 16'hA5C3);
    check("R9 level kept", {12'd0, irq_level}, 16'd11);
    check("R9 gpo kept", gpo, 16'hA5C3);

    // R10 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async level", {12'd0, irq_level}, 16'd0);
    check("R10 async gpo", gpo, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    irq_src = '0;
    @(negedge clk);
    rd("R10 mask cleared", 6'h00, 16'h0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule